// File: doc/BRIEF.md
# Gray-Scale PWM Engine with Prescaler

This block turns a set of per-channel 8-bit gray-scale levels into on/off enables for 16 LED sink channels. A slow gray-scale clock arrives as a plain level that the block samples with the system clock. Its falling edges drive an 8-bit step counter, and each channel stays lit for as many counting steps as its level. A 3-bit divider code stretches every counting step over 1 to 8 gray-scale falling edges. This dims the whole panel at once without rewriting any channel level.

A frame starts when the blank input is released. The block then waits for a gray-scale rising edge, and the falling edge after it lights every channel whose level is nonzero. Raising blank ends the frame and clears all channels. In narrow mode the 16 outputs act as eight tied pairs, and each pair follows one level byte. Registered copies of the gray-scale clock and of blank are provided so a cascaded downstream driver switches a little later. A kill input forces every enable low at once. Counting carries on while kill is high.

All inputs are plain control and level pins sampled on the system clock. No stream flows through the block, so there is no valid/ready handshake and no back-pressure. The level bytes must be held steady while a frame runs.

Top module: `gs_pwm_engine`

## Requirements
- R1: While blank is sampled high, every enable is 0 from the first system clock edge that samples it. A frame in progress is abandoned, and its count and prescaler phase are discarded.
- R2: A frame starts only at a gray-scale falling edge that follows a gray-scale rising edge seen while blank is low. Edges that happen before that rising edge do not start it. On the start edge, every channel with a nonzero level turns on.
- R3: A channel whose level is 0 never turns on.
- R4: The step counter is 0 at the start edge and advances by one per counting step. A channel turns off on the step where the counter reaches its level, so with division 1 a level of L stays lit for exactly L gray-scale falling edges. A level of 255 turns off on step 255.
- R5: With brightness-enable high, divider code n (0..7) makes each counting step take n+1 gray-scale falling edges. Code 2 means 3 falls per step, and code 7 means 8 falls per step.
- R6: With brightness-enable low, each falling edge is one step, whatever the divider code.
- R7: Level byte k sits at gs_data_i[8k+7:8k]. With wide_mode_i=1, output i follows byte i. With wide_mode_i=0, outputs 2k and 2k+1 both follow byte k, and bytes 8..15 are ignored.
- R8: Once a channel has turned off it stays off until blank goes high and low again, even if its level is raised. The step counter saturates at 255 and does not wrap.
- R9: kill_i forces all enables to 0 combinationally while it is high. The counter and prescaler keep running, so after release the enables show the current count.
- R10: gsclk_dly_o and blank_dly_o repeat gsclk_i and blank_i delayed by DLY_STAGES system clocks (2 by default).
- R11: After reset, all enables and both delayed copies are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gsclk_i | input | 1 | Gray-scale clock level, sampled on clk |
| blank_i | input | 1 | High forces all channels off and rearms the frame |
| wide_mode_i | input | 1 | 1: 16 independent channels; 0: 8 tied pairs |
| gs_data_i | input | 128 | Sixteen 8-bit levels, byte k at bits 8k+7:8k |
| div_code_i | input | 3 | Divider code n, counting step = n+1 falls |
| bright_en_i | input | 1 | 0 ignores div_code_i (division 1) |
| kill_i | input | 1 | Global off override |
| out_en_o | output | 16 | Per-channel sink enables |
| gsclk_dly_o | output | 1 | Delayed gray-scale clock for the next stage |
| blank_dly_o | output | 1 | Delayed blank for the next stage |

## Verification
A gray-scale edge is detected at the first system clock edge that samples the new level. Channel enables change at that same edge, one system clock after the bench drives the level, so each scenario task drives at a falling clock edge and checks at the next falling edge. Blank clears the enables one system clock after it is driven high. Kill gates the enables combinationally and is checked a few nanoseconds after it is driven. The delayed copies are checked once after one system clock, when they must not have moved yet, and again after two, when they must have arrived.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/gsp_edge_detect.sv
module gsp_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/gsp_sequencer.sv
module gsp_sequencer #(
  parameter int GS_W  = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             start_o,
  output logic             step_o,
  output logic [GS_W-1:0]  cnt_nxt_o
);
  import gsp_pkg::*;

  localparam logic [GS_W-1:0] CNT_MAX = {GS_W{1'b1}};

  seq_state_t       state_q;
  logic [DIV_W-1:0] presc_q;
  logic [GS_W-1:0]  cnt_q;
  logic             presc_wrap;

  assign presc_wrap = (presc_q == div_i);
  assign start_o    = (state_q == SEQ_ARMED) && fall_i && !blank_i;
  assign step_o     = (state_q == SEQ_RUN) && fall_i && !blank_i && presc_wrap;
  // saturating successor of the step count
  assign cnt_nxt_o  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (blank_i) begin
      state_q <= SEQ_IDLE;
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (rise_i) state_q <= SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (fall_i) begin
            state_q <= SEQ_RUN;
            presc_q <= '0;
            cnt_q   <= '0;
          end
        end
        SEQ_RUN: begin
          if (fall_i) begin
            if (presc_wrap) begin
              presc_q <= '0;
              cnt_q   <= cnt_nxt_o;
            end else begin
              presc_q <= presc_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gsp_channel.sv
module gsp_channel #(
  parameter int GS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blank_i,
  input  logic            start_i,
  input  logic            step_i,
  input  logic [GS_W-1:0] cnt_nxt_i,
  input  logic [GS_W-1:0] level_i,
  output logic            lit_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                                lit_o <= 1'b0;
    else if (blank_i)                          lit_o <= 1'b0;
    else if (start_i)                          lit_o <= (level_i != '0);
    else if (step_i && (cnt_nxt_i == level_i)) lit_o <= 1'b0;
  end
endmodule

// File: rtl/gsp_delay_line.sv
module gsp_delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_pipe
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/gs_pwm_engine.sv
module gs_pwm_engine #(
  parameter int NUM_CH     = 16,
  parameter int GS_W       = 8,
  parameter int DIV_W      = 3,
  parameter int DLY_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gsclk_i,
  input  logic                   blank_i,
  input  logic                   wide_mode_i,
  input  logic [NUM_CH*GS_W-1:0] gs_data_i,
  input  logic [DIV_W-1:0]       div_code_i,
  input  logic                   bright_en_i,
  input  logic                   kill_i,
  output logic [NUM_CH-1:0]      out_en_o,
  output logic                   gsclk_dly_o,
  output logic                   blank_dly_o
);
  logic             gs_rise, gs_fall;
  logic             start_p, step_p;
  logic [GS_W-1:0]  cnt_nxt;
  logic [DIV_W-1:0] div_eff;
  logic [NUM_CH-1:0] lit;

  assign div_eff = bright_en_i ? div_code_i : '0;

  gsp_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (gsclk_i),
    .rise_o (gs_rise),
    .fall_o (gs_fall)
  );

  gsp_sequencer #(.GS_W(GS_W), .DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .blank_i   (blank_i),
    .rise_i    (gs_rise),
    .fall_i    (gs_fall),
    .div_i     (div_eff),
    .start_o   (start_p),
    .step_o    (step_p),
    .cnt_nxt_o (cnt_nxt)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [GS_W-1:0] level;
      // narrow mode: outputs 2k and 2k+1 share byte k
      assign level = wide_mode_i ? gs_data_i[ch*GS_W +: GS_W]
                                 : gs_data_i[(ch/2)*GS_W +: GS_W];
      gsp_channel #(.GS_W(GS_W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .blank_i   (blank_i),
        .start_i   (start_p),
        .step_i    (step_p),
        .cnt_nxt_i (cnt_nxt),
        .level_i   (level),
        .lit_o     (lit[ch])
      );
    end
  endgenerate

  assign out_en_o = lit & ~{NUM_CH{kill_i}};

  gsp_delay_line #(.W(2), .DEPTH(DLY_STAGES)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({gsclk_i, blank_i}),
    .q_o   ({gsclk_dly_o, blank_dly_o})
  );
endmodule

// File: rtl/gsp_engine_chk.sv
module gsp_engine_chk #(
  parameter int NUM_CH     = 16,
  parameter int DLY_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gsclk_i,
  input logic              blank_i,
  input logic              wide_mode_i,
  input logic              kill_i,
  input logic [NUM_CH-1:0] out_en_o,
  input logic              gsclk_dly_o,
  input logic              blank_dly_o
);
  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end
  assign warm = since_rst[1];

  // R1
  blank_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(blank_i)) |-> (out_en_o == '0));

  // R2
  light_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !kill_i && !$past(kill_i) && (|(out_en_o & ~$past(out_en_o))))
      |-> ($past(gsclk_i, 2) && !$past(gsclk_i)));

  generate
    for (genvar k = 0; k < NUM_CH/2; k++) begin : g_pair
      // R7
      pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !wide_mode_i && !$past(wide_mode_i))
          |-> (out_en_o[2*k] == out_en_o[2*k+1]));
    end
    if (DLY_STAGES == 2) begin : g_dly
      // R10
      gsclk_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (gsclk_dly_o == $past(gsclk_i, 2)));
      // R10
      blank_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (blank_dly_o == $past(blank_i, 2)));
    end
  endgenerate
endmodule

bind gs_pwm_engine gsp_engine_chk #(
  .NUM_CH     (NUM_CH),
  .DLY_STAGES (DLY_STAGES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gsclk_i     (gsclk_i),
  .blank_i     (blank_i),
  .wide_mode_i (wide_mode_i),
  .kill_i      (kill_i),
  .out_en_o    (out_en_o),
  .gsclk_dly_o (gsclk_dly_o),
  .blank_dly_o (blank_dly_o)
);

// File: tb/tb_gs_pwm_engine.sv
module tb_gs_pwm_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gsclk = 1'b0;
  logic         blank = 1'b1;
  logic         wide = 1'b1;
  logic [127:0] gs_data = '0;
  logic [2:0]   div_code = '0;
  logic         bright_en = 1'b0;
  logic         kill = 1'b0;
  logic [15:0]  out_en;
  logic         gsclk_dly, blank_dly;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gs_pwm_engine dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .gsclk_i     (gsclk),
    .blank_i     (blank),
    .wide_mode_i (wide),
    .gs_data_i   (gs_data),
    .div_code_i  (div_code),
    .bright_en_i (bright_en),
    .kill_i      (kill),
    .out_en_o    (out_en),
    .gsclk_dly_o (gsclk_dly),
    .blank_dly_o (blank_dly)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gs_rise();
    gsclk = 1'b1; cyc(1);
  endtask

  task automatic gs_fall();
    gsclk = 1'b0; cyc(1);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin gs_rise(); gs_fall(); end
  endtask

  task automatic set_byte(input int idx, input logic [7:0] v);
    gs_data[idx*8 +: 8] = v;
  endtask

  task automatic begin_frame();
    blank = 1'b1; cyc(2);
    blank = 1'b0; gs_rise(); gs_fall();
  endtask

  task automatic t_reset();
    chk("R11 enables after reset", out_en, 16'h0000);
    chk("R11 gsclk copy after reset", gsclk_dly, 0);
  endtask

  task automatic t_basic();
    wide = 1'b1; bright_en = 1'b0;
    for (int i = 0; i < 16; i++) set_byte(i, 8'd2);
    set_byte(0, 8'd3); set_byte(1, 8'd0); set_byte(2, 8'd1); set_byte(3, 8'd255);
    begin_frame();
    chk("R2 start lights nonzero", out_en, 16'hFFFD);
    chk("R3 zero level stays dark", out_en[1], 0);
    pulses(1); chk("R4 level 1 off", out_en, 16'hFFF9);
    pulses(1); chk("R4 level 2 off", out_en, 16'h0009);
    pulses(1); chk("R4 level 3 off", out_en, 16'h0008);
    pulses(251); chk("R4 level 255 at step 254", out_en, 16'h0008);
    pulses(1); chk("R4 level 255 off", out_en, 16'h0000);
    pulses(5); chk("R8 saturated no wrap", out_en, 16'h0000);
    set_byte(0, 8'd100);
    pulses(1); chk("R8 raised level no relight", out_en, 16'h0000);
    begin_frame();
    chk("R8 relight after new blank", out_en, 16'hFFFD);
    blank = 1'b1; cyc(1);
    chk("R1 blank clears mid frame", out_en, 16'h0000);
  endtask

  task automatic t_start_align();
    wide = 1'b1; gs_data = '0; set_byte(4, 8'd5);
    blank = 1'b1; gsclk = 1'b1; cyc(2);
    blank = 1'b0; cyc(2);
    gs_fall();
    chk("R2 fall without prior rise", out_en, 16'h0000);
    gs_rise(); gs_fall();
    chk("R2 fall after rise starts", out_en, 16'h0010);
  endtask

  task automatic t_divider();
    wide = 1'b1; gs_data = '0; set_byte(5, 8'd2);
    bright_en = 1'b1; div_code = 3'd2;
    begin_frame();
    pulses(5); chk("R5 div3 still on after 5 falls", out_en, 16'h0020);
    pulses(1); chk("R5 div3 off after 6 falls", out_en, 16'h0000);
    set_byte(5, 8'd1); div_code = 3'd7;
    begin_frame();
    pulses(7); chk("R5 div8 on after 7 falls", out_en, 16'h0020);
    pulses(1); chk("R5 div8 off after 8 falls", out_en, 16'h0000);
    set_byte(5, 8'd2); bright_en = 1'b0;
    begin_frame();
    pulses(1); chk("R6 undivided on after 1 fall", out_en, 16'h0020);
    pulses(1); chk("R6 undivided off after 2 falls", out_en, 16'h0000);
  endtask

  task automatic t_narrow();
    blank = 1'b1; cyc(1);
    wide = 1'b0;
    gs_data = '0;
    set_byte(0, 8'd1); set_byte(1, 8'd3);
    for (int i = 8; i < 16; i++) set_byte(i, 8'd5);
    begin_frame();
    chk("R7 pairs from bytes 0..7", out_en, 16'h000F);
    pulses(1); chk("R7 pair 0 off", out_en, 16'h000C);
    pulses(2); chk("R7 pair 1 off", out_en, 16'h0000);
    blank = 1'b1; cyc(1);
    wide = 1'b1;
  endtask

  task automatic t_kill();
    wide = 1'b1; gs_data = '0; set_byte(0, 8'd10); bright_en = 1'b0;
    begin_frame();
    chk("R9 lit before kill", out_en, 16'h0001);
    pulses(2);
    kill = 1'b1; #1;
    chk("R9 kill forces off", out_en, 16'h0000);
    cyc(1); pulses(3);
    chk("R9 off during kill", out_en, 16'h0000);
    kill = 1'b0; #1;
    chk("R9 back on after release", out_en, 16'h0001);
    cyc(1); pulses(4);
    chk("R9 count kept running step 9", out_en, 16'h0001);
    pulses(1);
    chk("R9 off at step 10", out_en, 16'h0000);
  endtask

  task automatic t_delay();
    blank = 1'b0; gsclk = 1'b0; cyc(3);
    gsclk = 1'b1; blank = 1'b1; cyc(1);
    chk("R10 gsclk copy not yet", gsclk_dly, 0);
    chk("R10 blank copy not yet", blank_dly, 0);
    cyc(1);
    chk("R10 gsclk copy arrived", gsclk_dly, 1);
    chk("R10 blank copy arrived", blank_dly, 1);
    gsclk = 1'b0; cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_basic();
    t_start_align();
    t_divider();
    t_narrow();
    t_kill();
    t_delay();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule